// File: doc/BRIEF.md
# Serial Port Status Flags and Interrupt Request

This block keeps the four status flags of an asynchronous serial port and combines them into one interrupt request. It sits between the bus register file and the transmit and receive shift engines. The flags are: transmit holding empty, transmit finished, receive holding full, and receive line idle. The shift engines and the raw receive line set the flags. Software clears a flag with a two-step bus access. First it reads the status register while the flag is 1. Then it accesses the data register: a write for the two transmit flags, a read for the two receive flags.

The idle flag counts consecutive logic-1 bit samples on the receive line. The run length is 10 for the short frame setting and 11 for the long one. After the idle flag fires, it must see a 0 on the line before it can fire again. Each flag has its own enable bit. The interrupt output is the registered OR of the enabled flags.

Top module: `uart_stat_irq`

## Requirements
- R1: During and after reset, `flags_o` is 4'b0011 and `irq_o` is 0. The bit positions are: bit 0 transmit empty, bit 1 transmit finished, bit 2 receive full, bit 3 idle.
- R2: A cycle with `tx_load_i` high sets `flags_o[0]` at the next clock edge.
- R3: `flags_o[0]` is cleared by a `data_wr_i` cycle only when an earlier `stat_rd_i` cycle saw it at 1. A data write with no such read leaves it at 1.
- R4: `flags_o[1]` is set at the edge that ends a cycle meeting all of these conditions: `flags_o[0]` is 1, `tx_busy_i` is 0, and neither `data_wr_i` nor `tx_flag_clr_i` is high. While `tx_busy_i` is 1, `flags_o[1]` does not rise.
- R5: `flags_o[1]` clears through the same status-read-then-data-write sequence as `flags_o[0]`.
- R6: `rx_xfer_i` sets `flags_o[2]` at the next edge. A `data_rd_i` clears it only after a `stat_rd_i` that saw it at 1.
- R7: On `rx_tick_i` samples, `flags_o[3]` sets on the sample that completes a run of consecutive 1s on `rx_line_i`. The run is 10 samples with `long_frame_i`=0 and 11 with `long_frame_i`=1.
- R8: `flags_o[3]` clears by a status read that saw it set, followed by a data read. It does not set again until a 0 sample has been seen on `rx_line_i`.
- R9: A flag that was 0 at the status read is not cleared by the following data access, even if it sets in between.
- R10: `irq_o` equals the OR of (`flags_o` AND `irq_en_i`) from the previous cycle.
- R11: `tx_flag_clr_i` clears `flags_o[1:0]` at the next edge. They stay 0 until `tx_load_i`.
- R12: When a set event and a clear fall in the same cycle, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_load_i | input | 1 | Pulse: transmit data moved into the shift register |
| tx_busy_i | input | 1 | Transmitter shifting data, preamble or break |
| rx_xfer_i | input | 1 | Pulse: received character moved into the data register |
| rx_line_i | input | 1 | Raw receive line level |
| rx_tick_i | input | 1 | Bit-sample strobe for the receive line |
| long_frame_i | input | 1 | 1 selects the 11-bit idle run, 0 selects the 10-bit run |
| stat_rd_i | input | 1 | Bus read of the status register |
| data_rd_i | input | 1 | Bus read of the data register |
| data_wr_i | input | 1 | Bus write of the data register |
| tx_flag_clr_i | input | 1 | Software clear-to-zero of both transmit flags |
| irq_en_i | input | 4 | Per-flag interrupt enables, same bit order as the flags |
| flags_o | output | 4 | Flag vector |
| irq_o | output | 1 | Combined registered interrupt request |

## Verification
A wrongly held arm bit shows at the first data-register access after a status read. In that cycle a flag clears when it should stay set, or stays set when it should clear, and `flags_o` shows it at the next edge. A wrong idle run counter shows as `flags_o[3]` rising one sample early or late. It also shows as the flag rising a second time with no 0 sample in between. A fault in the interrupt gate appears on `irq_o` exactly one cycle after the flag or enable edge that should have moved it.

// File: rtl/uart_stat_pkg.sv
// Package: shared constants and flag index map for the serial port status logic.
// Assumes the four flags are kept in one vector in the order below.
package uart_stat_pkg;
    localparam int FLAG_N   = 4;
    localparam int IDX_TXE  = 0;  // transmit holding empty
    localparam int IDX_TC   = 1;  // transmit finished
    localparam int IDX_RXF  = 2;  // receive holding full
    localparam int IDX_IDLE = 3;  // receive line idle
    typedef logic [FLAG_N-1:0] flag_vec_t;
endpackage

// File: rtl/uart_flag_cell.sv
// One status flag with a two-step clear.
// A status read arms the clear only if the flag is 1 in that cycle. The next
// data access then clears it. A set event wins over any clear in the same cycle.
// Assumes that set_i, arm_i, access_i and force_clr_i are single-cycle strobes.
module uart_flag_cell #(
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic arm_i,
    input  logic access_i,
    input  logic force_clr_i,
    output logic flag_o
);
    logic flag_q;
    logic armed_q;
    logic clr_now;

    assign clr_now = force_clr_i | (access_i & armed_q);

    // Flag register: set has priority, then the armed or forced clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= RST_VAL;
        else if (set_i)   flag_q <= 1'b1;
        else if (clr_now) flag_q <= 1'b0;
    end

    // Arm register: remembers that a status read saw the flag at 1.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= (armed_q & ~access_i & ~force_clr_i)
                               | (arm_i & flag_q & ~clr_now);
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/uart_idle_det.sv
// Receive line idle detector.
// Counts consecutive 1 samples taken on rx_tick_i. It pulses set_o on the
// sample that completes a run of SHORT_RUN or SHORT_RUN+1 ones. After that it
// stays quiet until a 0 sample is seen.
// Assumes the tick arrives once per bit time from the receive engine.
module uart_idle_det #(
    parameter int SHORT_RUN = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic line_i,
    input  logic long_i,
    output logic set_o
);
    localparam int LONG_RUN = SHORT_RUN + 1;
    localparam int CW       = $clog2(LONG_RUN + 1);

    logic [CW-1:0] run_q;
    logic [CW-1:0] run_inc;
    logic [CW-1:0] target;
    logic          zero_seen_q;
    logic          hit;

    assign run_inc = run_q + 1'b1;
    assign target  = long_i ? CW'(LONG_RUN) : CW'(SHORT_RUN);
    assign hit     = tick_i & line_i & zero_seen_q & (run_inc == target);

    // Run counter: resets on a 0 sample and saturates at the long run length.
    always_ff @(posedge clk) begin
        if (!rst_n)                 run_q <= '0;
        else if (tick_i && !line_i) run_q <= '0;
        else if (tick_i && run_q != CW'(LONG_RUN)) run_q <= run_inc;
    end

    // Re-arm latch: a 0 sample allows the next idle detection.
    always_ff @(posedge clk) begin
        if (!rst_n)                 zero_seen_q <= 1'b1;
        else if (tick_i && !line_i) zero_seen_q <= 1'b1;
        else if (hit)               zero_seen_q <= 1'b0;
    end

    assign set_o = hit;
endmodule

// File: rtl/uart_irq_gate.sv
// Interrupt combiner: a registered OR of the flags masked by their enables.
// Assumes the flags and the enables are the same width and in the same order.
module uart_irq_gate #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flag_i,
    input  logic [N-1:0] en_i,
    output logic         irq_o
);
    logic irq_q;

    // Request register: one cycle after the flags or enables change.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(flag_i & en_i);
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/uart_stat_irq.sv
// Top of the serial port status and interrupt logic.
// Four flag cells are built by a generate loop. The two transmit flags reset
// to 1, clear on a data write and accept a software forced clear. The two
// receive flags reset to 0 and clear on a data read. Transmit finished is
// fed from the registered transmit-empty flag.
// Assumes all strobes are synchronous single-cycle pulses on clk.
module uart_stat_irq
    import uart_stat_pkg::*;
#(
    parameter int IDLE_RUN = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_load_i,
    input  logic              tx_busy_i,
    input  logic              rx_xfer_i,
    input  logic              rx_line_i,
    input  logic              rx_tick_i,
    input  logic              long_frame_i,
    input  logic              stat_rd_i,
    input  logic              data_rd_i,
    input  logic              data_wr_i,
    input  logic              tx_flag_clr_i,
    input  logic [FLAG_N-1:0] irq_en_i,
    output logic [FLAG_N-1:0] flags_o,
    output logic              irq_o
);
    flag_vec_t flag_q;
    flag_vec_t set_vec;
    logic      idle_set;

    uart_idle_det #(.SHORT_RUN(IDLE_RUN)) u_idle (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (rx_tick_i),
        .line_i (rx_line_i),
        .long_i (long_frame_i),
        .set_o  (idle_set)
    );

    // Set sources: transmit finished needs empty, a quiet line and no pending clear.
    always_comb begin
        set_vec           = '0;
        set_vec[IDX_TXE]  = tx_load_i;
        set_vec[IDX_TC]   = flag_q[IDX_TXE] & ~tx_busy_i & ~data_wr_i & ~tx_flag_clr_i;
        set_vec[IDX_RXF]  = rx_xfer_i;
        set_vec[IDX_IDLE] = idle_set;
    end

    for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
        localparam bit IS_TX = (g == IDX_TXE) || (g == IDX_TC);
        uart_flag_cell #(.RST_VAL(IS_TX)) u_cell (
            .clk         (clk),
            .rst_n       (rst_n),
            .set_i       (set_vec[g]),
            .arm_i       (stat_rd_i),
            .access_i    (IS_TX ? data_wr_i : data_rd_i),
            .force_clr_i (IS_TX ? tx_flag_clr_i : 1'b0),
            .flag_o      (flag_q[g])
        );
    end

    uart_irq_gate #(.N(FLAG_N)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .flag_i (flag_q),
        .en_i   (irq_en_i),
        .irq_o  (irq_o)
    );

    assign flags_o = flag_q;
endmodule

// File: rtl/uart_stat_irq_chk.sv
// Checker for uart_stat_irq. It watches only the ports and is attached by bind.
module uart_stat_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_load_i,
    input logic       tx_busy_i,
    input logic       rx_xfer_i,
    input logic       data_rd_i,
    input logic       data_wr_i,
    input logic       tx_flag_clr_i,
    input logic [3:0] irq_en_i,
    input logic [3:0] flags_o,
    input logic       irq_o
);
    // R2: a transmit load always leaves the empty flag set.
    assert_txe_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load_i |=> flags_o[0]);

    // R3: without a data write or a forced clear, the empty flag holds.
    assert_txe_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[0] && !data_wr_i && !tx_flag_clr_i) |=> flags_o[0]);

    // R4: transmit finished never rises while the transmitter is busy.
    assert_tc_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!flags_o[1] && tx_busy_i) |=> !flags_o[1]);

    // R6: receive full is set by a transfer and holds without a data read.
    assert_rxf_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_xfer_i |=> flags_o[2]);
    assert_rxf_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[2] && !data_rd_i) |=> flags_o[2]);

    // R8: idle holds without a data read.
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[3] && !data_rd_i) |=> flags_o[3]);

    // R10: the interrupt follows the masked flags one cycle later.
    assert_irq_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flags_o & irq_en_i)) |=> irq_o);
    assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(flags_o & irq_en_i)) |=> !irq_o);

    // R11: a forced clear without a load empties the transmit flag.
    assert_force_clr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_flag_clr_i && !tx_load_i) |=> !flags_o[0]);
endmodule

bind uart_stat_irq uart_stat_irq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_load_i     (tx_load_i),
    .tx_busy_i     (tx_busy_i),
    .rx_xfer_i     (rx_xfer_i),
    .data_rd_i     (data_rd_i),
    .data_wr_i     (data_wr_i),
    .tx_flag_clr_i (tx_flag_clr_i),
    .irq_en_i      (irq_en_i),
    .flags_o       (flags_o),
    .irq_o         (irq_o)
);

// File: tb/uart_stat_irq_tb_top.sv
// Directed bench for uart_stat_irq. Inputs are driven on falling edges and
// outputs are sampled on falling edges, one rising edge after the stimulus.
module uart_stat_irq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_load_i = 0, tx_busy_i = 0, rx_xfer_i = 0;
    logic       rx_line_i = 1, rx_tick_i = 0, long_frame_i = 0;
    logic       stat_rd_i = 0, data_rd_i = 0, data_wr_i = 0, tx_flag_clr_i = 0;
    logic [3:0] irq_en_i = 4'b0000;
    logic [3:0] flags_o;
    logic       irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;  // 50 MHz

    uart_stat_irq dut_i (
        .clk(clk), .rst_n(rst_n), .tx_load_i(tx_load_i), .tx_busy_i(tx_busy_i),
        .rx_xfer_i(rx_xfer_i), .rx_line_i(rx_line_i), .rx_tick_i(rx_tick_i),
        .long_frame_i(long_frame_i), .stat_rd_i(stat_rd_i), .data_rd_i(data_rd_i),
        .data_wr_i(data_wr_i), .tx_flag_clr_i(tx_flag_clr_i), .irq_en_i(irq_en_i),
        .flags_o(flags_o), .irq_o(irq_o)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_stat_rd();  stat_rd_i = 1; step(1); stat_rd_i = 0; endtask
    task automatic pulse_data_rd();  data_rd_i = 1; step(1); data_rd_i = 0; endtask
    task automatic pulse_data_wr();  data_wr_i = 1; step(1); data_wr_i = 0; endtask
    task automatic pulse_rx_xfer();  rx_xfer_i = 1; step(1); rx_xfer_i = 0; endtask
    task automatic tick(input logic v);
        rx_line_i = v; rx_tick_i = 1; step(1); rx_tick_i = 0; rx_line_i = 1;
    endtask

    task automatic t_reset();
        chk("R1 flags in reset", flags_o, 4'b0011);
        chk("R1 irq in reset", irq_o, 1'b0);
        rst_n = 1; step(1);
        chk("R1 flags after reset", flags_o, 4'b0011);
        chk("R1 irq after reset", irq_o, 1'b0);
    endtask

    task automatic t_tx_sequence();
        pulse_data_wr();
        chk("R3 write without read keeps empty", flags_o[0], 1'b1);
        pulse_stat_rd();
        pulse_data_wr();
        chk("R3 read then write clears empty", flags_o[0], 1'b0);
        chk("R5 read then write clears finished", flags_o[1], 1'b0);
        tx_busy_i = 1; tx_load_i = 1; step(1); tx_load_i = 0;
        chk("R2 load sets empty", flags_o[0], 1'b1);
        step(3);
        chk("R4 finished stays low while busy", flags_o[1], 1'b0);
        tx_busy_i = 0; step(1);
        chk("R4 finished sets once idle", flags_o[1], 1'b1);
    endtask

    task automatic t_rx_sequence();
        pulse_rx_xfer();
        chk("R6 transfer sets full", flags_o[2], 1'b1);
        pulse_data_rd();
        chk("R6 read without status keeps full", flags_o[2], 1'b1);
        pulse_stat_rd();
        pulse_data_rd();
        chk("R6 status then data read clears full", flags_o[2], 1'b0);
    endtask

    task automatic t_late_set();
        pulse_stat_rd();
        pulse_rx_xfer();
        pulse_data_rd();
        chk("R9 flag set after status read survives", flags_o[2], 1'b1);
        pulse_stat_rd();
        pulse_data_rd();
        chk("R9 later sequence clears it", flags_o[2], 1'b0);
    endtask

    task automatic t_set_wins();
        pulse_rx_xfer();
        pulse_stat_rd();
        data_rd_i = 1; rx_xfer_i = 1; step(1); data_rd_i = 0; rx_xfer_i = 0;
        chk("R12 set beats clear", flags_o[2], 1'b1);
        pulse_stat_rd();
        pulse_data_rd();
        chk("R12 cleanup clears full", flags_o[2], 1'b0);
    endtask

    task automatic t_idle();
        long_frame_i = 0;
        tick(1'b0);
        for (int i = 0; i < 9; i++) tick(1'b1);
        chk("R7 nine ones not idle", flags_o[3], 1'b0);
        tick(1'b1);
        chk("R7 tenth one sets idle", flags_o[3], 1'b1);
        pulse_stat_rd();
        pulse_data_rd();
        chk("R8 status then data read clears idle", flags_o[3], 1'b0);
        for (int i = 0; i < 12; i++) tick(1'b1);
        chk("R8 no re-set without a zero", flags_o[3], 1'b0);
        long_frame_i = 1;
        tick(1'b0);
        for (int i = 0; i < 10; i++) tick(1'b1);
        chk("R7 long frame ten ones not idle", flags_o[3], 1'b0);
        tick(1'b1);
        chk("R7 long frame eleventh one sets idle", flags_o[3], 1'b1);
        pulse_stat_rd();
        pulse_data_rd();
        chk("R8 long frame clear", flags_o[3], 1'b0);
        long_frame_i = 0;
    endtask

    task automatic t_irq();
        // Flags here: transmit empty and finished are 1, receive and idle are 0.
        irq_en_i = 4'b0100;
        step(1);
        chk("R10 disabled flags give no irq", irq_o, 1'b0);
        irq_en_i = 4'b0010;
        #1;
        chk("R10 irq not yet raised", irq_o, 1'b0);
        step(1);
        chk("R10 irq raised one cycle later", irq_o, 1'b1);
        irq_en_i = 4'b0000;
        step(1);
        chk("R10 irq drops after mask", irq_o, 1'b0);
    endtask

    task automatic t_init_clear();
        tx_flag_clr_i = 1; step(1); tx_flag_clr_i = 0;
        chk("R11 forced clear zeroes tx flags", flags_o[1:0], 2'b00);
        step(3);
        chk("R11 tx flags stay zero", flags_o[1:0], 2'b00);
        tx_load_i = 1; step(1); tx_load_i = 0;
        chk("R11 load sets empty", flags_o[1:0], 2'b01);
        step(1);
        chk("R4 finished follows empty", flags_o[1:0], 2'b11);
    endtask

    initial begin
        step(3);
        t_reset();
        t_tx_sequence();
        t_rx_sequence();
        t_late_set();
        t_set_wins();
        t_idle();
        t_irq();
        t_init_clear();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule